// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip request bus and an external 16-bit asynchronous static RAM with a 20-bit word address. It accepts one read or write at a time through a valid/ready handshake. For each request it plays out a fixed strobe sequence on the memory pins and then signals completion with a one-cycle done pulse. A read's done pulse comes with the read data. The data pins are bidirectional, but the controller reaches them only through separate out, in and drive-enable signals, so the pad cells stay outside the block.

All memory timing is taken from nanosecond parameters. At elaboration each one is rounded up to a whole number of controller clocks, using at least one clock wherever the minimum is nonzero, so one netlist can be retargeted to another clock or another speed grade by changing parameters only. After reset the controller holds off every request until a power-up wait has run out. It also puts one quiet cycle between a read and a write that follows it at once, so that the memory and the controller never drive the data bus together.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_dq_oe`, `req_ready` and `rsp_done` are low, and `rsp_rdata` is zero.
- R2: After reset is released, `req_ready` stays low for ceil(T_PWRUP_NS/CLK_NS) cycles and then goes high while the controller is idle. It is low during every cycle of an access, and no strobe is active while it is high.
- R3: The memory is selected (`mem_ce1_n` low and `mem_ce2` high together) only during an access. In every other cycle both select pins are inactive.
- R4: A read holds `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` low for AA = max(1, ceil(max(T_AA_NS,T_RC_NS)/CLK_NS)) cycles, beginning the cycle after acceptance. `mem_lb_n` is low only if `req_be[0]` was set (data bits 7:0) and `mem_ub_n` is low only if `req_be[1]` was set (bits 15:8).
- R5: Read data is sampled on the last cycle of the read window. `rsp_rdata` shows it from the following cycle, and any lane whose byte enable was clear reads as zero.
- R6: A write holds `mem_we_n` low for WP = max(1, ceil(max of pulse width, data setup, select-to-end, address-to-end and byte-to-end)/CLK_NS) cycles, beginning the cycle after acceptance. A recovery of max(0, ceil(T_WC_NS/CLK_NS) − WP) cycles follows with `mem_we_n` high. Through both phases select is held, `mem_oe_n` is high, `mem_dq_oe` is high and `mem_dq_out` carries the request data.
- R7: On a write the byte-lane pins follow `req_be` as in R4, and only the enabled lanes of the addressed word change.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low, and it is high only during the two write phases.
- R9: A write accepted in the done cycle of a read is preceded by exactly one cycle with all strobes inactive and `req_ready` low. A write accepted after an idle cycle starts at once.
- R10: A request with `req_be`=0 produces no select, write or output-enable strobe. Its done pulse comes in the next cycle, and neither the memory nor `rsp_rdata` changes.
- R11: `rsp_done` is high for one cycle per accepted request: the cycle after the last strobe cycle, or the cycle after acceptance for R10 requests.
- R12: `mem_addr` holds the accepted address and does not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data of the last completed read |
| mem_addr | output | 20 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low low-byte enable |
| mem_ub_n | output | 1 | Active-low high-byte enable |
| mem_dq_out | output | 16 | Data to the pad drivers |
| mem_dq_in | input | 16 | Data from the pad receivers |
| mem_dq_oe | output | 1 | Pad driver enable |

## Verification
Some rules must hold in every cycle, and the assertions check them: no bus contention between `mem_dq_oe` and `mem_oe_n`, a write strobe only under select with at least one byte lane, a read strobe only with write high, no strobes while ready, and a steady address under select. The exact phase lengths in cycles, the turnaround cycle that appears only after a read, the masking of unselected read lanes, byte-lane merging in memory and the no-operation path depend on request order and history. Only the bench's cycle-by-cycle reference model can show these, as it runs fixed and random request streams against a behavioural memory.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 10,
  parameter int T_PWRUP_NS = 150000,
  parameter int T_RC_NS    = 15,
  parameter int T_AA_NS    = 15,
  parameter int T_WC_NS    = 15,
  parameter int T_PWE_NS   = 10,
  parameter int T_SCE_NS   = 10,
  parameter int T_AW_NS    = 10,
  parameter int T_BW_NS    = 10,
  parameter int T_SD_NS    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  function automatic int ns2cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LANE_W  = DATA_W / 2;
  localparam int AA_CYC  = imax(1, ns2cyc(imax(T_AA_NS, T_RC_NS)));
  localparam int WP_CYC  = imax(1, ns2cyc(imax(imax(T_PWE_NS, T_SD_NS),
                                               imax(imax(T_SCE_NS, T_AW_NS), T_BW_NS))));
  localparam int WC_CYC  = ns2cyc(T_WC_NS);
  localparam int REC_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 0;
  localparam int PWR_CYC = imax(1, ns2cyc(T_PWRUP_NS));
  localparam int MAX_CYC = imax(imax(AA_CYC, WP_CYC), imax(REC_CYC, PWR_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] AA_LD  = CNT_W'(AA_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC - 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_TURN, ST_RD, ST_WP, ST_WREC
  } st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       be_q;
  logic             after_rd;

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_PWR;
      cnt        <= PWR_LD;
      be_q       <= '0;
      after_rd   <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      after_rd <= 1'b0;
      case (state)
        ST_PWR: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end

        ST_IDLE: begin
          if (req_valid) begin
            be_q <= req_be;
            if (req_be == 2'b00) begin
              rsp_done <= 1'b1;
            end else begin
              mem_addr   <= req_addr;
              mem_dq_out <= req_wdata;
              if (req_write && after_rd) begin
                state <= ST_TURN;
              end else begin
                mem_ce1_n <= 1'b0;
                mem_ce2   <= 1'b1;
                mem_lb_n  <= ~req_be[0];
                mem_ub_n  <= ~req_be[1];
                if (req_write) begin
                  state     <= ST_WP;
                  cnt       <= WP_LD;
                  mem_we_n  <= 1'b0;
                  mem_dq_oe <= 1'b1;
                end else begin
                  state    <= ST_RD;
                  cnt      <= AA_LD;
                  mem_oe_n <= 1'b0;
                end
              end
            end
          end
        end

        ST_TURN: begin
          state     <= ST_WP;
          cnt       <= WP_LD;
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_lb_n  <= ~be_q[0];
          mem_ub_n  <= ~be_q[1];
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
        end

        ST_RD: begin
          if (cnt == '0) begin
            rsp_rdata <= mem_dq_in & {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};
            rsp_done  <= 1'b1;
            after_rd  <= 1'b1;
            state     <= ST_IDLE;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end

        ST_WP: begin
          if (cnt == '0) begin
            mem_we_n <= 1'b1;
            if (REC_CYC == 0) begin
              rsp_done  <= 1'b1;
              state     <= ST_IDLE;
              mem_ce1_n <= 1'b1;
              mem_ce2   <= 1'b0;
              mem_lb_n  <= 1'b1;
              mem_ub_n  <= 1'b1;
              mem_dq_oe <= 1'b0;
            end else begin
              state <= ST_WREC;
              cnt   <= REC_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end

        ST_WREC: begin
          if (cnt == '0) begin
            rsp_done  <= 1'b1;
            state     <= ST_IDLE;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_we_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && !(mem_lb_n && mem_ub_n)));

  p_read_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int CLK_NS   = 10;
  localparam int PWRUP_NS = 300;
  localparam int PWR = (PWRUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WP  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int WC  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int REC = (WC > WP) ? WC - WP : 0;
  localparam int WDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS), .T_PWRUP_NS(PWRUP_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  // behavioural memory: 64 words selected by the low address bits, 8'hEE on lanes not driven
  logic [15:0] sram [64];
  logic        msel;
  assign msel = !mem_ce1_n && mem_ce2;
  assign mem_dq_in = (msel && !mem_oe_n && mem_we_n)
    ? {mem_ub_n ? 8'hEE : sram[mem_addr[5:0]][15:8], mem_lb_n ? 8'hEE : sram[mem_addr[5:0]][7:0]}
    : 16'hEEEE;
  always @(posedge clk)
    if (msel && !mem_we_n) begin
      if (!mem_lb_n) sram[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) sram[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end

  typedef struct {
    bit sel, oe, we, lb, ub, dqoe, ready, done, rd;
    logic [19:0] addr;
    logic [15:0] wd, rdv;
    string tag;
  } frame_t;

  typedef struct {
    bit wr;
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0] be;
    int gap;
  } op_t;

  frame_t fq[$];
  op_t    oq[$];
  logic [15:0] shadow [64];
  logic [15:0] exp_rd;
  int checks = 0, fails = 0, cyc = 0;
  bit prev_rd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic frame_t blank(input bit ready, input string tag);
    frame_t f;
    f.sel = 0; f.oe = 0; f.we = 0; f.lb = 0; f.ub = 0; f.dqoe = 0;
    f.ready = ready; f.done = 0; f.rd = 0; f.addr = '0; f.wd = '0; f.rdv = '0; f.tag = tag;
    return f;
  endfunction

  task automatic compare(input frame_t f);
    string lt;
    lt = (f.tag == "R6") ? "R7" : f.tag;
    chk(mem_ce1_n == !f.sel && mem_ce2 == f.sel, f.tag, "select", {mem_ce1_n, mem_ce2}, {!f.sel, f.sel});
    chk(mem_oe_n == !f.oe, f.tag, "oe_n", mem_oe_n, !f.oe);
    chk(mem_we_n == !f.we, f.tag, "we_n", mem_we_n, !f.we);
    chk(mem_lb_n == !f.lb && mem_ub_n == !f.ub, lt, "byte lanes", {mem_ub_n, mem_lb_n}, {!f.ub, !f.lb});
    chk(mem_dq_oe == f.dqoe, "R8", "dq_oe", mem_dq_oe, f.dqoe);
    chk(req_ready == f.ready, "R2", "ready", req_ready, f.ready);
    chk(rsp_done == f.done, "R11", "done", rsp_done, f.done);
    if (f.done && f.rd) exp_rd = f.rdv;
    chk(rsp_rdata == exp_rd, "R5", "rdata", rsp_rdata, exp_rd);
    if (f.sel) chk(mem_addr == f.addr, "R12", "address", mem_addr, f.addr);
    if (f.dqoe) chk(mem_dq_out == f.wd, "R6", "write data", mem_dq_out, f.wd);
  endtask

  task automatic issue(input op_t o);
    frame_t f;
    logic [15:0] m;
    req_valid = 1; req_write = o.wr; req_addr = o.a; req_wdata = o.d; req_be = o.be;
    m = {{8{o.be[1]}}, {8{o.be[0]}}};
    if (o.be == 2'b00) begin
      f = blank(1, "R10"); f.done = 1; fq.push_back(f);
    end else if (!o.wr) begin
      for (int i = 0; i < AA; i++) begin
        f = blank(0, "R4"); f.sel = 1; f.oe = 1; f.lb = o.be[0]; f.ub = o.be[1]; f.addr = o.a;
        fq.push_back(f);
      end
      f = blank(1, "R5"); f.done = 1; f.rd = 1; f.rdv = shadow[o.a[5:0]] & m; fq.push_back(f);
    end else begin
      if (prev_rd) fq.push_back(blank(0, "R9"));
      for (int i = 0; i < WP + REC; i++) begin
        f = blank(0, "R6"); f.sel = 1; f.we = (i < WP); f.lb = o.be[0]; f.ub = o.be[1];
        f.dqoe = 1; f.addr = o.a; f.wd = o.d;
        fq.push_back(f);
      end
      f = blank(1, "R11"); f.done = 1; fq.push_back(f);
      shadow[o.a[5:0]] = (shadow[o.a[5:0]] & ~m) | (o.d & m);
    end
  endtask

  task automatic add_op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int gap);
    op_t o;
    o.wr = wr; o.a = a; o.d = d; o.be = be; o.gap = gap;
    oq.push_back(o);
  endtask

  initial begin
    frame_t f;
    for (int i = 0; i < 64; i++) begin sram[i] = '0; shadow[i] = '0; end
    exp_rd = '0; prev_rd = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(mem_ce1_n && !mem_ce2, "R1", "select in reset", {mem_ce1_n, mem_ce2}, 2'b10);
    chk(mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1", "strobes in reset",
        {mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 4'hF);
    chk(!mem_dq_oe && !req_ready && !rsp_done, "R1", "oe/ready/done in reset",
        {mem_dq_oe, req_ready, rsp_done}, 3'b000);
    chk(rsp_rdata == 16'h0, "R1", "rdata in reset", rsp_rdata, 16'h0);
    rst_n = 1;
    for (int i = 0; i < PWR; i++) fq.push_back(blank(0, "R2"));

    // fixed scenarios
    add_op(1, 20'hABC01, 16'h1234, 2'b11, 0);  // full write
    add_op(0, 20'hABC01, 16'h0000, 2'b11, 0);  // full read
    add_op(1, 20'hABC01, 16'hFF56, 2'b01, 2);  // low lane write only (R7), after gap
    add_op(0, 20'h00001, 16'h0000, 2'b11, 0);  // aliased read
    add_op(1, 20'h12302, 16'h9A00, 2'b10, 3);  // high lane only
    add_op(0, 20'h12302, 16'h0000, 2'b01, 0);  // low lane read, high masked
    add_op(0, 20'hABC01, 16'h0000, 2'b10, 0);  // high lane read
    add_op(1, 20'hABC01, 16'hDEAD, 2'b00, 0);  // R10 write no-op
    add_op(0, 20'hABC01, 16'h0000, 2'b11, 0);
    add_op(0, 20'hFFFFF, 16'h0000, 2'b00, 0);  // R10 read no-op keeps rdata
    add_op(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    add_op(1, 20'hFFFFF, 16'hC0DE, 2'b11, 0);  // R9 turnaround after read
    add_op(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    add_op(1, 20'h00000, 16'h5A5A, 2'b11, 1);  // gap: no turnaround
    add_op(1, 20'h00003, 16'hA5A5, 2'b11, 0);  // back-to-back writes
    add_op(0, 20'h00000, 16'h0000, 2'b11, 0);
    add_op(0, 20'h00003, 16'h0000, 2'b11, 0);
    for (int i = 0; i < 300; i++)
      add_op(1'($urandom), 20'($urandom), 16'($urandom), 2'($urandom),
             (($urandom % 3) == 0) ? int'($urandom % 3) : 0);

    while ((oq.size() != 0 || fq.size() != 0) && cyc < WDOG) begin
      f = (fq.size() != 0) ? fq.pop_front() : blank(1, "R3");
      compare(f);
      prev_rd = f.done && f.rd;
      req_valid = 0;
      if (f.ready && oq.size() != 0) begin
        if (oq[0].gap > 0) oq[0].gap = oq[0].gap - 1;
        else issue(oq.pop_front());
      end
      @(negedge clk);
      cyc++;
    end
    if (cyc >= WDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
    end
    for (int i = 0; i < 4; i++) begin
      compare(blank(1, "R3"));
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule